// File: doc/BRIEF.md
# Resolver Converter Configuration Register File

This block is the register side of a resolver-to-digital converter's serial port. An SPI slave shifter ahead of it hands over one received 8-bit frame at a time as a single-cycle strobe. In return, the block presents the byte to be shifted out during the next frame. Frames count only while the two mode inputs select configuration mode. Frames that arrive in position mode, velocity mode or the unused code are dropped.

Address bytes and data bytes share one stream and are told apart by their most significant bit. A byte with that bit set selects a register and loads that register's contents for read-back. A byte with that bit clear carries seven bits of data for the register selected last. A host reads a register by sending its address and then any second valid address. The contents come back during that second frame, and no write takes place. The block holds seven threshold registers, the excitation frequency word, the control register, a sticky fault register and a write-only restart trigger. It also reflects the live position and velocity words when they are read. A small state machine tracks the selection. Its states are `S_IDLE`, where no register is selected; `S_ARMED`, where a register is selected; and `S_KICK`, the single cycle after a write to the restart address. An address byte moves the machine from `S_IDLE` or `S_KICK` to `S_ARMED`. A data byte sent to the restart address moves it from `S_ARMED` to `S_KICK`. Leaving configuration mode returns it from any state to `S_IDLE`.

Top module: `resolver_cfg_regfile`

## Requirements
- R1: After reset the control word is 0x3F, every threshold is 0, the excitation word is 0x28, `tx_byte` is 0x00 and `exc_restart` is low.
- R2: While `mode_sel` is not 2'b11, frames are ignored and no stored value or `tx_byte` changes. Leaving configuration mode drops the selection, so a data byte that arrives after configuration mode is re-entered, and before any new address byte, writes nothing.
- R3: A data byte (bit 7 = 0) writes its low seven bits to the selected threshold register (0x88 to 0x8E, threshold i at 0x88+i) or to the control register (0x92). The selection persists, so further data bytes write to the same register.
- R4: In the cycle after an address byte, `tx_byte` holds the contents of the addressed register. For a read/write register, bit 7 of that byte is the parity flag and bits 6:0 are the stored value. After an accepted data byte, `tx_byte` is 0x00. An unlisted address reads as 0x00.
- R5: Addresses 0x80/0x81 return the high and low bytes of `pos_word`, and 0x82/0x83 return the high and low bytes of `vel_word`, taken in the cycle of the address byte.
- R6: Address bytes never write anything. Data bytes sent to the read-only addresses 0x80 to 0x83, or to unlisted addresses, change no state and read back as before.
- R7: A write to the excitation word (0x91) takes effect only if the value lies in 0x04..0x50 inclusive. Other values are ignored.
- R8: A data byte sent to 0xF0 raises `exc_restart` for exactly the cycle after that frame and changes no configuration register.
- R9: Each write stores an odd parity bit over the address and the seven data bits, and that bit is inverted if `par_inject` is high during the write. On read-back, bit 7 is 1 exactly when the stored bit disagrees with the recomputed parity, that is, when `par_inject` was high during the write that stored the value.
- R10: The fault register (0xFF) ORs `fault_in` into itself every cycle, and all eight of its bits are fault bits, including bit 7. A data byte sent to 0xFF reloads it with that cycle's `fault_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Output mode select; 2'b11 is configuration |
| rx_valid | input | 1 | One-cycle strobe: a received frame is present |
| rx_byte | input | 8 | Received frame |
| par_inject | input | 1 | Corrupts the parity bit stored by a write |
| pos_word | input | 16 | Live angle word |
| vel_word | input | 16 | Live speed word |
| fault_in | input | 8 | Fault event flags from the monitors |
| tx_byte | output | 8 | Byte to shift out in the next frame |
| exc_word | output | 7 | Excitation frequency control word |
| ctrl_word | output | 7 | Control register |
| thr_flat | output | 49 | Thresholds, threshold i at bits [7i+6:7i] |
| exc_restart | output | 1 | One-cycle excitation restart pulse |

## Verification
The bench uses the default parameters: seven thresholds, an excitation range of 0x04 to 0x50, and reset values of 0x28 and 0x3F. With these values, both edges of the excitation range can be probed just inside and just outside (0x03, 0x04, 0x50 and 0x51). Every threshold address is reachable, including the last one, 0x8E. A behavioural reference model of the register map, written with plain arrays, predicts `tx_byte`, all configuration outputs and the restart pulse on every clock. Directed sequences cover mode changes in the middle of a transaction, corrupted parity, and fault accumulation and clearing.

// File: rtl/resolver_cfg_pkg.sv
package resolver_cfg_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ARMED = 2'd1,
        S_KICK  = 2'd2
    } sel_state_t;

    localparam logic [1:0] MODE_CFG   = 2'b11;
    localparam logic [7:0] A_POS_HI   = 8'h80;
    localparam logic [7:0] A_POS_LO   = 8'h81;
    localparam logic [7:0] A_VEL_HI   = 8'h82;
    localparam logic [7:0] A_VEL_LO   = 8'h83;
    localparam logic [7:0] A_THR_BASE = 8'h88;
    localparam logic [7:0] A_EXC      = 8'h91;
    localparam logic [7:0] A_CTRL     = 8'h92;
    localparam logic [7:0] A_KICK     = 8'hF0;
    localparam logic [7:0] A_FAULT    = 8'hFF;

    // Bit that makes the total count of ones over {addr, data, bit} odd.
    function automatic logic odd_par(input logic [7:0] a, input logic [6:0] d);
        return ~(^{a, d});
    endfunction

endpackage

// File: rtl/cfg_frame_fsm.sv
module cfg_frame_fsm
    import resolver_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_mode,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    output logic       ld_addr,
    output logic       wr_en,
    output logic [7:0] ptr,
    output logic       kick
);

    sel_state_t state_q, state_d;
    logic [7:0] ptr_q, ptr_d;

    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        if (!cfg_mode) begin
            state_d = S_IDLE;
        end else if (rx_valid) begin
            unique case (state_q)
                S_IDLE: begin
                    if (rx_byte[7]) begin
                        state_d = S_ARMED;
                        ptr_d   = rx_byte;
                    end
                end
                S_ARMED, S_KICK: begin
                    if (rx_byte[7]) begin
                        state_d = S_ARMED;
                        ptr_d   = rx_byte;
                    end else begin
                        state_d = (ptr_q == A_KICK) ? S_KICK : S_ARMED;
                    end
                end
                default: state_d = S_IDLE;
            endcase
        end else if (state_q == S_KICK) begin
            state_d = S_ARMED;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ptr_q   <= 8'h00;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    always_comb begin
        ld_addr = cfg_mode && rx_valid && rx_byte[7];
        wr_en   = cfg_mode && rx_valid && !rx_byte[7] && (state_q != S_IDLE);
        ptr     = ptr_q;
        kick    = (state_q == S_KICK);
    end

endmodule

// File: rtl/cfg_fault_latch.sv
module cfg_fault_latch #(
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reload,
    input  logic [FW-1:0] fault_in,
    output logic [FW-1:0] fault_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      fault_q <= '0;
        else if (reload) fault_q <= fault_in;
        else             fault_q <= fault_q | fault_in;
    end

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
    import resolver_cfg_pkg::*;
#(
    parameter int NUM_THR  = 7,
    parameter int EXC_MIN  = 4,
    parameter int EXC_MAX  = 80,
    parameter int EXC_RST  = 40,
    parameter int CTRL_RST = 63
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [7:0]           wr_addr,
    input  logic [6:0]           wr_data,
    input  logic                 par_inject,
    input  logic [7:0]           rd_addr,
    input  logic [15:0]          pos_word,
    input  logic [15:0]          vel_word,
    input  logic [7:0]           fault_in,
    output logic [7:0]           rd_data,
    output logic [6:0]           exc_word,
    output logic [6:0]           ctrl_word,
    output logic [NUM_THR*7-1:0] thr_flat
);

    localparam logic [6:0] EXC_LO = 7'(EXC_MIN);
    localparam logic [6:0] EXC_HI = 7'(EXC_MAX);
    localparam logic [6:0] EXC_R  = 7'(EXC_RST);
    localparam logic [6:0] CTL_R  = 7'(CTRL_RST);

    logic [6:0]         thr_q [NUM_THR];
    logic [NUM_THR-1:0] thr_par;
    logic               exc_par, ctl_par;
    logic [7:0]         fault_q;

    for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
        localparam logic [7:0] THR_ADDR = A_THR_BASE + 8'(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                thr_q[g]   <= 7'd0;
                thr_par[g] <= odd_par(THR_ADDR, 7'd0);
            end else if (wr_en && wr_addr == THR_ADDR) begin
                thr_q[g]   <= wr_data;
                thr_par[g] <= odd_par(THR_ADDR, wr_data) ^ par_inject;
            end
        end
        assign thr_flat[g*7 +: 7] = thr_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exc_word <= EXC_R;
            exc_par  <= odd_par(A_EXC, EXC_R);
        end else if (wr_en && wr_addr == A_EXC && wr_data >= EXC_LO && wr_data <= EXC_HI) begin
            exc_word <= wr_data;
            exc_par  <= odd_par(A_EXC, wr_data) ^ par_inject;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_word <= CTL_R;
            ctl_par   <= odd_par(A_CTRL, CTL_R);
        end else if (wr_en && wr_addr == A_CTRL) begin
            ctrl_word <= wr_data;
            ctl_par   <= odd_par(A_CTRL, wr_data) ^ par_inject;
        end
    end

    cfg_fault_latch #(.FW(8)) u_fault (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload   (wr_en && wr_addr == A_FAULT),
        .fault_in (fault_in),
        .fault_q  (fault_q)
    );

    always_comb begin
        rd_data = 8'h00;
        unique case (rd_addr)
            A_POS_HI: rd_data = pos_word[15:8];
            A_POS_LO: rd_data = pos_word[7:0];
            A_VEL_HI: rd_data = vel_word[15:8];
            A_VEL_LO: rd_data = vel_word[7:0];
            A_EXC:    rd_data = {exc_par ^ odd_par(A_EXC, exc_word), exc_word};
            A_CTRL:   rd_data = {ctl_par ^ odd_par(A_CTRL, ctrl_word), ctrl_word};
            A_FAULT:  rd_data = fault_q;
            default:  rd_data = 8'h00;
        endcase
        for (int i = 0; i < NUM_THR; i++) begin
            if (rd_addr == A_THR_BASE + 8'(i))
                rd_data = {thr_par[i] ^ odd_par(rd_addr, thr_q[i]), thr_q[i]};
        end
    end

endmodule

// File: rtl/resolver_cfg_regfile.sv
module resolver_cfg_regfile
    import resolver_cfg_pkg::*;
#(
    parameter int NUM_THR  = 7,
    parameter int EXC_MIN  = 4,
    parameter int EXC_MAX  = 80,
    parameter int EXC_RST  = 40,
    parameter int CTRL_RST = 63
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode_sel,
    input  logic                 rx_valid,
    input  logic [7:0]           rx_byte,
    input  logic                 par_inject,
    input  logic [15:0]          pos_word,
    input  logic [15:0]          vel_word,
    input  logic [7:0]           fault_in,
    output logic [7:0]           tx_byte,
    output logic [6:0]           exc_word,
    output logic [6:0]           ctrl_word,
    output logic [NUM_THR*7-1:0] thr_flat,
    output logic                 exc_restart
);

    logic       cfg_mode, ld_addr, wr_en;
    logic [7:0] ptr, rd_data;

    assign cfg_mode = (mode_sel == MODE_CFG);

    cfg_frame_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_mode (cfg_mode),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .ld_addr  (ld_addr),
        .wr_en    (wr_en),
        .ptr      (ptr),
        .kick     (exc_restart)
    );

    cfg_regbank #(
        .NUM_THR  (NUM_THR),
        .EXC_MIN  (EXC_MIN),
        .EXC_MAX  (EXC_MAX),
        .EXC_RST  (EXC_RST),
        .CTRL_RST (CTRL_RST)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (ptr),
        .wr_data    (rx_byte[6:0]),
        .par_inject (par_inject),
        .rd_addr    (rx_byte),
        .pos_word   (pos_word),
        .vel_word   (vel_word),
        .fault_in   (fault_in),
        .rd_data    (rd_data),
        .exc_word   (exc_word),
        .ctrl_word  (ctrl_word),
        .thr_flat   (thr_flat)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tx_byte <= 8'h00;
        else if (ld_addr) tx_byte <= rd_data;
        else if (wr_en)   tx_byte <= 8'h00;
    end

endmodule

// File: rtl/resolver_cfg_checker.sv
module resolver_cfg_checker #(
    parameter int NUM_THR = 7,
    parameter int EXC_MIN = 4,
    parameter int EXC_MAX = 80
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           mode_sel,
    input logic                 rx_valid,
    input logic [7:0]           rx_byte,
    input logic [7:0]           tx_byte,
    input logic [6:0]           exc_word,
    input logic [6:0]           ctrl_word,
    input logic [NUM_THR*7-1:0] thr_flat,
    input logic                 exc_restart,
    input logic                 wr_en
);

    localparam logic [6:0] LO = 7'(EXC_MIN);
    localparam logic [6:0] HI = 7'(EXC_MAX);

    a_r2_hold_outside_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel != 2'b11) |=> ($stable(ctrl_word) && $stable(exc_word)
                                 && $stable(thr_flat) && $stable(tx_byte)));

    a_r4_tx_clear_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tx_byte == 8'h00));

    a_r6_addr_byte_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_byte[7]) |=> ($stable(ctrl_word) && $stable(exc_word) && $stable(thr_flat)));

    a_r7_exc_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_word >= LO) && (exc_word <= HI));

    a_r8_restart_cause: assert property (@(posedge clk) disable iff (!rst_n)
        exc_restart |-> $past(rx_valid && !rx_byte[7] && mode_sel == 2'b11));

endmodule

bind resolver_cfg_regfile resolver_cfg_checker #(
    .NUM_THR (NUM_THR),
    .EXC_MIN (EXC_MIN),
    .EXC_MAX (EXC_MAX)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_sel    (mode_sel),
    .rx_valid    (rx_valid),
    .rx_byte     (rx_byte),
    .tx_byte     (tx_byte),
    .exc_word    (exc_word),
    .ctrl_word   (ctrl_word),
    .thr_flat    (thr_flat),
    .exc_restart (exc_restart),
    .wr_en       (wr_en)
);

// File: tb/resolver_cfg_regfile_bench.sv
module resolver_cfg_regfile_bench;

    localparam int NT = 7;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [1:0]    mode_sel = 2'b11;
    logic          rx_valid = 0;
    logic [7:0]    rx_byte = 0;
    logic          par_inject = 0;
    logic [15:0]   pos_word = 0;
    logic [15:0]   vel_word = 0;
    logic [7:0]    fault_in = 0;
    logic [7:0]    tx_byte;
    logic [6:0]    exc_word, ctrl_word;
    logic [NT*7-1:0] thr_flat;
    logic          exc_restart;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    resolver_cfg_regfile u_resolver_cfg_regfile (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .par_inject(par_inject), .pos_word(pos_word),
        .vel_word(vel_word), .fault_in(fault_in), .tx_byte(tx_byte),
        .exc_word(exc_word), .ctrl_word(ctrl_word), .thr_flat(thr_flat),
        .exc_restart(exc_restart)
    );

    // Behavioural reference model
    int  m_thr [NT];
    bit  m_thr_bad [NT];
    int  m_exc, m_ctrl, m_fault, m_tx, m_ptr;
    bit  m_exc_bad, m_ctrl_bad, m_armed, m_restart, m_ready;

    function automatic int m_read(int a);
        if (a == 'h80) return pos_word[15:8];
        if (a == 'h81) return pos_word[7:0];
        if (a == 'h82) return vel_word[15:8];
        if (a == 'h83) return vel_word[7:0];
        if (a >= 'h88 && a < 'h88 + NT) return m_thr[a-'h88] + (m_thr_bad[a-'h88] ? 128 : 0);
        if (a == 'h91) return m_exc + (m_exc_bad ? 128 : 0);
        if (a == 'h92) return m_ctrl + (m_ctrl_bad ? 128 : 0);
        if (a == 'hFF) return m_fault;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_thr[i]) begin m_thr[i] = 0; m_thr_bad[i] = 0; end
            m_exc = 'h28; m_ctrl = 'h3F; m_fault = 0; m_tx = 0; m_ptr = 0;
            m_exc_bad = 0; m_ctrl_bad = 0; m_armed = 0; m_restart = 0; m_ready = 1;
        end else begin
            bit fault_reload;
            fault_reload = 0;
            m_restart = 0;
            if (mode_sel != 2'b11) begin
                m_armed = 0;
            end else if (rx_valid) begin
                if (rx_byte[7]) begin
                    m_tx = m_read(rx_byte);
                    m_ptr = rx_byte;
                    m_armed = 1;
                end else if (m_armed) begin
                    int v;
                    v = rx_byte[6:0];
                    m_tx = 0;
                    if (m_ptr >= 'h88 && m_ptr < 'h88 + NT) begin
                        m_thr[m_ptr-'h88] = v; m_thr_bad[m_ptr-'h88] = par_inject;
                    end else if (m_ptr == 'h91) begin
                        if (v >= 4 && v <= 'h50) begin m_exc = v; m_exc_bad = par_inject; end
                    end else if (m_ptr == 'h92) begin
                        m_ctrl = v; m_ctrl_bad = par_inject;
                    end else if (m_ptr == 'hF0) begin
                        m_restart = 1;
                    end else if (m_ptr == 'hFF) begin
                        fault_reload = 1;
                    end
                end
            end
            m_fault = fault_reload ? int'(fault_in) : (m_fault | int'(fault_in));
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && m_ready) begin
            chk("R4 tx_byte", tx_byte, m_tx);
            chk("R7 exc_word", exc_word, m_exc);
            chk("R3 ctrl_word", ctrl_word, m_ctrl);
            for (int i = 0; i < NT; i++) chk("R3 threshold", thr_flat[i*7 +: 7], m_thr[i]);
            chk("R8 exc_restart", exc_restart, m_restart);
        end
    end

    task automatic send(input logic [7:0] b);
        @(posedge clk); #2;
        rx_valid = 1; rx_byte = b;
        @(posedge clk); #2;
        rx_valid = 0;
    endtask

    task automatic rd(input logic [7:0] a, input string req, input int exp);
        send(a);
        chk(req, tx_byte, exp);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        #2;
        // R1 reset state
        chk("R1 ctrl", ctrl_word, 'h3F);
        chk("R1 exc", exc_word, 'h28);
        chk("R1 tx", tx_byte, 0);
        chk("R1 thr", thr_flat, 0);
        chk("R1 restart", exc_restart, 0);

        // R2 frames outside configuration mode
        mode_sel = 2'b00;
        send(8'h88); send(8'h15);
        chk("R2 thr0 untouched", thr_flat[6:0], 0);
        chk("R2 tx untouched", tx_byte, 0);
        mode_sel = 2'b11;

        // R3 writes with persistent selection, R4 read-back
        send(8'h88); send(8'h15);
        chk("R3 thr0", thr_flat[6:0], 'h15);
        send(8'h2A);
        chk("R3 thr0 second", thr_flat[6:0], 'h2A);
        rd(8'h88, "R4 read thr0", 'h2A);
        send(8'h8E); send(8'h7F);
        chk("R3 thr6", thr_flat[48:42], 'h7F);

        // R2 leaving config mode drops selection
        @(posedge clk); #2 mode_sel = 2'b01;
        @(posedge clk); #2 mode_sel = 2'b11;
        send(8'h11);
        chk("R2 selection dropped", thr_flat[48:42], 'h7F);

        // R5 live words
        pos_word = 16'hBEEF; vel_word = 16'h8001;
        rd(8'h80, "R5 pos hi", 'hBE);
        rd(8'h81, "R5 pos lo", 'hEF);
        rd(8'h82, "R5 vel hi", 'h80);
        rd(8'h83, "R5 vel lo", 'h01);

        // R6 read-only / unlisted writes ignored
        send(8'h80); send(8'h55);
        rd(8'h80, "R6 pos unchanged", 'hBE);
        send(8'h85); send(8'h66);
        rd(8'h85, "R6 unlisted reads zero", 0);
        chk("R6 ctrl unchanged", ctrl_word, 'h3F);

        // R7 excitation range
        send(8'h91); send(8'h03);
        chk("R7 below min", exc_word, 'h28);
        send(8'h04);
        chk("R7 at min", exc_word, 'h04);
        send(8'h50);
        chk("R7 at max", exc_word, 'h50);
        send(8'h51);
        chk("R7 above max", exc_word, 'h50);

        // R8 restart pulse
        send(8'hF0);
        send(8'h00);
        chk("R8 pulse high", exc_restart, 1);
        chk("R8 ctrl unchanged", ctrl_word, 'h3F);
        @(posedge clk); #2;
        chk("R8 pulse one cycle", exc_restart, 0);

        // R9 parity flag
        par_inject = 1;
        send(8'h89); send(8'h33);
        par_inject = 0;
        rd(8'h89, "R9 injected flag", 'hB3);
        send(8'h34);
        rd(8'h89, "R9 clean flag", 'h34);
        send(8'h92); send(8'h05);
        rd(8'h92, "R9 ctrl clean", 'h05);

        // R10 fault register
        @(posedge clk); #2 fault_in = 8'h81;
        @(posedge clk); #2 fault_in = 8'h00;
        rd(8'hFF, "R10 sticky fault", 'h81);
        send(8'h00);
        rd(8'hFF, "R10 fault cleared", 0);

        repeat (3) @(posedge clk);
        #2;
        finish_run();
    end

endmodule